// File: doc/BRIEF.md
# Configurable Audio Serial Frame Transmitter

This block shifts parallel audio samples out on a single serial data line. The timing comes from outside the block. A one-cycle strobe marks each rising bit-clock edge, and a frame-sync level is sampled on those strobes. A protocol descriptor sets the layout of each frame:

- one or two phases per frame;
- for two phases, whether phase 2 follows phase 1 at once or waits for its own frame sync;
- the data delay after sync;
- the sync polarity;
- the bit order;
- the element length: 8, 16 or 32 bits.

Three fixed profiles cover the common cases: an I2S-style stereo-word profile, a PCM profile and a companded-PCM profile. A fourth, custom, profile takes every field from its own inputs.

Samples enter through a valid/ready port into one holding register. Each element sent consumes one sample. If an element starts while the holding register is empty, the block sends zeros and sets a sticky underrun flag. Dropping the enable lets the current frame finish. After that no new frame starts and the line stays low.

Top module: `audio_frame_tx`

## Requirements
- R1: After reset `sd_out` is 0, `underrun` is 0 and `smp_ready` is 1.
- R2: A frame starts on the first `bit_tick` at which `fsync_in` is at its active level after being inactive on the previous tick. It starts only while `en` is 1. A sync held active over several ticks starts one frame only.
- R3: The first bit of phase 1 is driven on the tick that lies `delay` ticks after the frame-start tick. With delay 0 it is driven on the frame-start tick itself.
- R4: Bits go most significant first unless the custom profile (`prof_sel`=3) has `cust_lsb_first`=1. In that case bit 0 of the element goes first.
- R5: Each `prof_sel` value selects a fixed descriptor:

  | `prof_sel` | Profile | Phases | Length | Delay | Sync active | Phase 2 start | Bit order |
  |---|---|---|---|---|---|---|---|
  | 0 | I2S-style | one | 32 | 1 | low | – | MSB first |
  | 1 | PCM | two | 16 | 0 | high | on its own sync | MSB first |
  | 2 | companded PCM | one | 8 | 0 | high | – | MSB first |
  | 3 | custom | `cust_dual` | `size_sel` | `cust_delay` | low if `cust_fs_low`=1 | from `cust_p2_on_sync` | from `cust_lsb_first` |

- R6: Profiles 0 to 2 use their own length when `keep_prof_len`=1. When `keep_prof_len`=0, and always for the custom profile, the length comes from `size_sel`: 0 gives 8, 1 gives 16, 2 or 3 gives 32. An element of length L carries bits L-1..0 of its sample.
- R7: In two-phase mode with immediate start, the first bit of phase 2 follows the last bit of phase 1 on the next tick.
- R8: In two-phase mode with sync start, the line stays low after phase 1. Phase 2 begins `delay` ticks after the next sync activation.
- R9: Outside element bits the line is driven low.
- R10: Every element consumes one sample from the holding register. `smp_ready` is 1 exactly when that register is empty.
- R11: If an element starts with no sample held, zeros are sent for it and `underrun` is set. It stays set until a `clr_underrun` pulse.
- R12: When `en` is cleared during a frame, that frame completes unchanged. Later sync activations send nothing and consume no sample.
- R13: `sd_out` changes only in the cycle after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Transmit enable, checked at frame start |
| prof_sel | input | 2 | Profile select: 0 I2S-style, 1 PCM, 2 companded PCM, 3 custom |
| keep_prof_len | input | 1 | 1 = use the profile's element length |
| size_sel | input | 2 | Element length select: 0 = 8, 1 = 16, 2 or 3 = 32 |
| cust_dual | input | 1 | Custom: two phases per frame |
| cust_p2_on_sync | input | 1 | Custom: phase 2 waits for its own sync |
| cust_delay | input | 2 | Custom: data delay in bit clocks (0 to 3) |
| cust_fs_low | input | 1 | Custom: sync is active low |
| cust_lsb_first | input | 1 | Custom: send bit 0 first |
| bit_tick | input | 1 | One-cycle strobe at each rising bit-clock edge |
| fsync_in | input | 1 | Frame-sync level |
| smp_data | input | SAMPLE_W | Sample word |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Holding register empty |
| clr_underrun | input | 1 | Clears the underrun flag |
| sd_out | output | 1 | Serial data line |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A wrong count of remaining bits or a wrong delay counter shows up on `sd_out` within the same frame. Bits appear shifted by one or more ticks, or a bit is repeated or cut short, so the first wrong tick shows the fault. A sequencer stuck outside its idle state shows up either as a missing next frame or, in two-phase sync mode, as a phase 2 that never starts. A holding register that loses or keeps a sample wrongly shows up as wrong `smp_ready` after a push, or as zeros or a stale word in the next element, with the underrun flag set on the same frame.

// File: rtl/atx_pkg.sv
// Shared types for the audio frame transmitter.
// Assumes element lengths never exceed 32 bits.
package atx_pkg;
    localparam int LEN_W = 6;

    typedef enum logic [1:0] {
        PROF_I2S  = 2'd0,
        PROF_PCM  = 2'd1,
        PROF_CPCM = 2'd2,
        PROF_CUST = 2'd3
    } atx_prof_e;

    typedef struct packed {
        logic             dual;
        logic             p2_sync;
        logic [1:0]       delay;
        logic             fs_low;
        logic             lsb_first;
        logic [LEN_W-1:0] len;
    } atx_desc_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DLY   = 2'd1,
        S_SHIFT = 2'd2,
        S_GAP   = 2'd3
    } atx_state_e;

    // Map a size code to an element length in bits.
    function automatic logic [LEN_W-1:0] size_len(input logic [1:0] code);
        case (code)
            2'd0:    size_len = LEN_W'(8);
            2'd1:    size_len = LEN_W'(16);
            default: size_len = LEN_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/atx_profile_dec.sv
// Turns the profile select and custom fields into one frame descriptor.
// Purely combinational; the sequencer decides when to sample it.
module atx_profile_dec
    import atx_pkg::*;
(
    input  logic [1:0] prof_sel,
    input  logic       keep_prof_len,
    input  logic [1:0] size_sel,
    input  logic       cust_dual,
    input  logic       cust_p2_on_sync,
    input  logic [1:0] cust_delay,
    input  logic       cust_fs_low,
    input  logic       cust_lsb_first,
    output atx_desc_t  desc
);
    logic [LEN_W-1:0] req_len;

    // Length requested through the size code.
    assign req_len = size_len(size_sel);

    // Select the descriptor for the chosen profile.
    always_comb begin
        desc = '0;
        case (atx_prof_e'(prof_sel))
            PROF_I2S: begin
                desc.delay  = 2'd1;
                desc.fs_low = 1'b1;
                desc.len    = keep_prof_len ? LEN_W'(32) : req_len;
            end
            PROF_PCM: begin
                desc.dual    = 1'b1;
                desc.p2_sync = 1'b1;
                desc.len     = keep_prof_len ? LEN_W'(16) : req_len;
            end
            PROF_CPCM: begin
                desc.len = keep_prof_len ? LEN_W'(8) : req_len;
            end
            default: begin
                desc.dual      = cust_dual;
                desc.p2_sync   = cust_p2_on_sync;
                desc.delay     = cust_delay;
                desc.fs_low    = cust_fs_low;
                desc.lsb_first = cust_lsb_first;
                desc.len       = req_len;
            end
        endcase
    end
endmodule

// File: rtl/atx_hold_reg.sv
// Single-entry sample holding register with a valid/ready input.
// Assumes the consumer raises take only while full is high.
module atx_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready = !full_q;
    assign full     = full_q;
    assign data     = data_q;

    // Fill on handshake, empty when the sequencer takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    a_r10_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> full_q);
    a_r10_held_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take) |=> (full_q && $stable(data_q)));
    a_r10_take_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full_q);
endmodule

// File: rtl/atx_frame_seq.sv
// Frame sequencer and shifter. All work happens on bit_tick cycles.
// Sync polarity is taken live; every other descriptor field is captured
// at frame start and holds for the whole frame.
module atx_frame_seq
    import atx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_tick,
    input  logic         fsync_in,
    input  atx_desc_t    live,
    input  logic         hold_full,
    input  logic [W-1:0] hold_data,
    input  logic         clr_underrun,
    output logic         take,
    output logic         sd_out,
    output logic         underrun
);
    localparam int SH_W = $clog2(W) + 1;

    atx_state_e       st, st_n;
    atx_desc_t        cfg_q, cfg_n, desc;
    logic [1:0]       cnt, cnt_n;
    logic [LEN_W-1:0] left, left_n;
    logic [W-1:0]     sh, sh_n, word, aligned;
    logic [SH_W-1:0]  shamt;
    logic             sd_q, sd_n, ph2, ph2_n, prev_act, act, fs_edge;
    logic             start_elem, begin_ph, use_live, ur_q;

    assign act      = fsync_in ^ live.fs_low;
    assign fs_edge  = bit_tick && act && !prev_act;
    assign sd_out   = sd_q;
    assign underrun = ur_q;

    // Next-state, shift and sample-take decisions for one tick.
    always_comb begin
        st_n = st; cnt_n = cnt; left_n = left; sh_n = sh; sd_n = sd_q;
        cfg_n = cfg_q; ph2_n = ph2; take = 1'b0;
        start_elem = 1'b0; begin_ph = 1'b0; use_live = 1'b0;
        word = '0; aligned = '0; shamt = '0;
        if (bit_tick) begin
            case (st)
                S_IDLE: if (fs_edge && en) begin
                    cfg_n = live; use_live = 1'b1; ph2_n = 1'b0; begin_ph = 1'b1;
                end
                S_DLY: if (cnt == 2'd0) start_elem = 1'b1;
                       else cnt_n = cnt - 2'd1;
                S_SHIFT: begin
                    if (left > LEN_W'(1)) begin
                        sd_n   = cfg_q.lsb_first ? sh[0] : sh[W-1];
                        sh_n   = cfg_q.lsb_first ? (sh >> 1) : (sh << 1);
                        left_n = left - LEN_W'(1);
                    end else if (!ph2 && cfg_q.dual && !cfg_q.p2_sync) begin
                        ph2_n = 1'b1; start_elem = 1'b1;
                    end else if (!ph2 && cfg_q.dual) begin
                        if (fs_edge) begin
                            ph2_n = 1'b1; begin_ph = 1'b1;
                        end else begin
                            st_n = S_GAP; sd_n = 1'b0;
                        end
                    end else if (fs_edge && en) begin
                        cfg_n = live; use_live = 1'b1; ph2_n = 1'b0; begin_ph = 1'b1;
                    end else begin
                        st_n = S_IDLE; sd_n = 1'b0;
                    end
                end
                default: if (fs_edge) begin
                    ph2_n = 1'b1; begin_ph = 1'b1;
                end
            endcase
        end
        desc = use_live ? live : cfg_q;
        if (begin_ph) begin
            if (desc.delay == 2'd0) begin
                start_elem = 1'b1;
            end else begin
                st_n = S_DLY; cnt_n = desc.delay - 2'd1; sd_n = 1'b0;
            end
        end
        if (start_elem) begin
            take   = hold_full;
            word   = hold_full ? hold_data : '0;
            st_n   = S_SHIFT;
            left_n = desc.len;
            shamt  = SH_W'(W) - SH_W'(desc.len);
            if (desc.lsb_first) begin
                sd_n = word[0];
                sh_n = word >> 1;
            end else begin
                aligned = word << shamt;
                sd_n    = aligned[W-1];
                sh_n    = aligned << 1;
            end
        end
    end

    // State, shifter and sync history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; cfg_q <= '0; cnt <= '0; left <= '0; sh <= '0;
            sd_q <= 1'b0; ph2 <= 1'b0; prev_act <= 1'b0;
        end else begin
            st <= st_n; cfg_q <= cfg_n; cnt <= cnt_n; left <= left_n;
            sh <= sh_n; sd_q <= sd_n; ph2 <= ph2_n;
            if (bit_tick) prev_act <= act;
        end
    end

    // Sticky underrun flag: set on an empty element start, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ur_q <= 1'b0;
        else if (start_elem && !hold_full) ur_q <= 1'b1;
        else if (clr_underrun)            ur_q <= 1'b0;
    end

    a_r13_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(sd_out));
    a_r12_stay_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !en) |=> (st == S_IDLE));
    a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_q && !clr_underrun) |=> ur_q);
    a_r9_low_outside_elements: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_SHIFT) |-> !sd_q);
    a_r3_shift_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT) |-> (left != '0 && left <= LEN_W'(W)));
endmodule

// File: rtl/audio_frame_tx.sv
// Top of the audio serial frame transmitter: descriptor decode, sample
// holding register and frame sequencer. Timing is given by bit_tick.
module audio_frame_tx #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [1:0]          prof_sel,
    input  logic                keep_prof_len,
    input  logic [1:0]          size_sel,
    input  logic                cust_dual,
    input  logic                cust_p2_on_sync,
    input  logic [1:0]          cust_delay,
    input  logic                cust_fs_low,
    input  logic                cust_lsb_first,
    input  logic                bit_tick,
    input  logic                fsync_in,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic                clr_underrun,
    output logic                sd_out,
    output logic                underrun
);
    atx_pkg::atx_desc_t  live_desc;
    logic                hold_full, take;
    logic [SAMPLE_W-1:0] hold_data;

    atx_profile_dec u_dec (
        .prof_sel(prof_sel), .keep_prof_len(keep_prof_len), .size_sel(size_sel),
        .cust_dual(cust_dual), .cust_p2_on_sync(cust_p2_on_sync),
        .cust_delay(cust_delay), .cust_fs_low(cust_fs_low),
        .cust_lsb_first(cust_lsb_first), .desc(live_desc)
    );

    atx_hold_reg #(.W(SAMPLE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .in_data(smp_data), .in_valid(smp_valid),
        .in_ready(smp_ready), .take(take), .full(hold_full), .data(hold_data)
    );

    atx_frame_seq #(.W(SAMPLE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick), .fsync_in(fsync_in),
        .live(live_desc), .hold_full(hold_full), .hold_data(hold_data),
        .clr_underrun(clr_underrun), .take(take), .sd_out(sd_out), .underrun(underrun)
    );
endmodule

// File: tb/audio_frame_tx_tb.sv
module audio_frame_tx_tb;
    logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic [1:0]  prof_sel = 2'd0, size_sel = 2'd0, cust_delay = 2'd0;
    logic        keep_prof_len = 1'b1, cust_dual = 1'b0, cust_p2_on_sync = 1'b0;
    logic        cust_fs_low = 1'b0, cust_lsb_first = 1'b0;
    logic        bit_tick = 1'b0, fsync_in = 1'b0, smp_valid = 1'b0, clr_underrun = 1'b0;
    logic [31:0] smp_data = '0;
    logic        smp_ready, sd_out, underrun;
    int          checks = 0, errors = 0;
    bit          exp_ur = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    audio_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .prof_sel(prof_sel),
        .keep_prof_len(keep_prof_len), .size_sel(size_sel), .cust_dual(cust_dual),
        .cust_p2_on_sync(cust_p2_on_sync), .cust_delay(cust_delay),
        .cust_fs_low(cust_fs_low), .cust_lsb_first(cust_lsb_first),
        .bit_tick(bit_tick), .fsync_in(fsync_in), .smp_data(smp_data),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .clr_underrun(clr_underrun),
        .sd_out(sd_out), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Descriptor expected from the current settings (R5, R6).
    task automatic decode(output int len, output int d, output int du, output int p2,
                          output int lo, output int ls);
        int sl;
        sl = (size_sel == 2'd0) ? 8 : (size_sel == 2'd1) ? 16 : 32;
        du = 0; p2 = 0; lo = 0; ls = 0; d = 0;
        case (prof_sel)
            2'd0: begin d = 1; lo = 1; len = keep_prof_len ? 32 : sl; end
            2'd1: begin du = 1; p2 = 1; len = keep_prof_len ? 16 : sl; end
            2'd2: len = keep_prof_len ? 8 : sl;
            default: begin
                du = cust_dual; p2 = cust_p2_on_sync; d = cust_delay;
                lo = cust_fs_low; ls = cust_lsb_first; len = sl;
            end
        endcase
    endtask

    // Bit expected on the line for an element of length len.
    function automatic bit elem_bit(input logic [31:0] w, input int idx, input int len, input int ls);
        return ls ? w[idx] : w[len-1-idx];
    endfunction

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = w;
        while (!smp_ready) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(smp_ready === 1'b0, "R10", {31'd0, smp_ready}, 32'd0);
    endtask

    // One bit-clock tick: drive, sample after the edge, check it holds (R13).
    task automatic tick(input logic pin, output logic v);
        @(negedge clk); fsync_in = pin; bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0; v = sd_out;
        @(negedge clk);
        chk(sd_out === v, "R13", {31'd0, sd_out}, {31'd0, v});
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [31:0] w1, input logic [31:0] w2,
                             input bit h1, input bit p1, input bit h2, input bit clr,
                             input int fw, input int gap, input int off_at, input string tag);
        int len, d, du, p2, lo, ls, s2, last;
        logic v;
        bit e, lvl;
        string t;
        decode(len, d, du, p2, lo, ls);
        s2 = d + len + gap;
        last = du ? (p2 ? s2 + d + len : d + 2 * len) : d + len;
        if (clr) begin
            @(negedge clk); clr_underrun = 1'b1;
            @(negedge clk); clr_underrun = 1'b0; exp_ur = 1'b0;
        end
        if (p1) push(w1);
        tick(lo[0], v);
        chk(v === 1'b0, "R9", {31'd0, v}, 32'd0);
        for (int k = 0; k < last + 2; k++) begin
            lvl = (k < fw) || (du != 0 && p2 != 0 && k == s2);
            if (k == off_at) en = 1'b0;
            tick(lvl ^ lo[0], v);
            e = 1'b0; t = "R9";
            if (k >= d && k < d + len) begin
                e = h1 ? elem_bit(w1, k - d, len, ls) : 1'b0; t = tag;
            end else if (du != 0) begin
                int st2;
                st2 = p2 ? s2 + d : d + len;
                if (k >= st2 && k < st2 + len) begin
                    e = h2 ? elem_bit(w2, k - st2, len, ls) : 1'b0;
                    t = p2 ? "R8" : "R7";
                end
            end
            chk(v === e, t, {31'd0, v}, {31'd0, e});
            if (du != 0 && h2 && k == d) push(w2);
        end
        exp_ur = exp_ur | !h1 | (du != 0 && !h2);
        chk(underrun === exp_ur, "R11", {31'd0, underrun}, {31'd0, exp_ur});
    endtask

    task automatic set_cust(input logic [1:0] sz, input bit du, input bit p2,
                            input logic [1:0] d, input bit lo, input bit ls);
        prof_sel = 2'd3; size_sel = sz; cust_dual = du; cust_p2_on_sync = p2;
        cust_delay = d; cust_fs_low = lo; cust_lsb_first = ls;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sd_out === 1'b0, "R1", {31'd0, sd_out}, 32'd0);
        chk(underrun === 1'b0, "R1", {31'd0, underrun}, 32'd0);
        chk(smp_ready === 1'b1, "R1", {31'd0, smp_ready}, 32'd1);
        en = 1'b1;

        // R5: each fixed profile, R2: wide sync starts one frame
        prof_sel = 2'd0; keep_prof_len = 1'b1;
        run_frame(32'hA5C3_0F81, '0, 1, 1, 0, 1, 3, 0, -1, "R5");
        prof_sel = 2'd1;
        run_frame(32'h0000_B2D4, 32'h0000_4E17, 1, 1, 1, 1, 1, 2, -1, "R5");
        prof_sel = 2'd2;
        run_frame(32'h0000_00C9, '0, 1, 1, 0, 1, 2, 0, -1, "R5");
        // R6: length override in a fixed profile
        prof_sel = 2'd0; keep_prof_len = 1'b0; size_sel = 2'd1;
        run_frame(32'hFFFF_9A3C, '0, 1, 1, 0, 1, 1, 0, -1, "R6");
        keep_prof_len = 1'b1;
        // R4: least significant bit first
        set_cust(2'd1, 0, 0, 2'd2, 1, 1);
        run_frame(32'h0000_8C31, '0, 1, 1, 0, 1, 1, 0, -1, "R4");
        // R7: two phases back to back
        set_cust(2'd0, 1, 0, 2'd0, 0, 0);
        run_frame(32'h0000_00B7, 32'h0000_0059, 1, 1, 1, 1, 1, 0, -1, "R7");
        // R2: sync held active four ticks
        set_cust(2'd0, 0, 0, 2'd1, 0, 0);
        run_frame(32'h0000_006D, '0, 1, 1, 0, 1, 4, 0, -1, "R2");
        // R11: underrun sends zeros and stays set across a good frame
        run_frame('0, '0, 0, 0, 0, 1, 1, 0, -1, "R11");
        run_frame(32'h0000_00E2, '0, 1, 1, 0, 0, 1, 0, -1, "R11");
        @(negedge clk); clr_underrun = 1'b1;
        @(negedge clk); clr_underrun = 1'b0; exp_ur = 1'b0;
        @(negedge clk);
        chk(underrun === 1'b0, "R11", {31'd0, underrun}, 32'd0);

        // R12: disable mid-frame, frame completes
        run_frame(32'h0000_0093, '0, 1, 1, 0, 1, 1, 0, 2, "R12");
        push(32'h0000_005A);
        tick(1'b0, v);
        for (int k = 0; k < 14; k++) begin
            tick(k == 0 || k == 11, v);
            chk(v === 1'b0, "R12", {31'd0, v}, 32'd0);
        end
        chk(smp_ready === 1'b0, "R12", {31'd0, smp_ready}, 32'd0);
        chk(underrun === 1'b0, "R12", {31'd0, underrun}, 32'd0);
        en = 1'b1;
        run_frame(32'h0000_005A, '0, 1, 0, 0, 1, 1, 0, -1, "R12");
        chk(smp_ready === 1'b1, "R10", {31'd0, smp_ready}, 32'd1);

        // R3: random descriptors and samples
        for (int n = 0; n < 40; n++) begin
            logic [31:0] a, b;
            bit ha, hb;
            prof_sel = 2'($urandom % 4); keep_prof_len = 1'($urandom % 2);
            size_sel = 2'($urandom % 4); cust_dual = 1'($urandom % 2);
            cust_p2_on_sync = 1'($urandom % 2); cust_delay = 2'($urandom % 4);
            cust_fs_low = 1'($urandom % 2); cust_lsb_first = 1'($urandom % 2);
            a = $urandom; b = $urandom;
            ha = ($urandom % 8) != 0; hb = ($urandom % 8) != 0;
            run_frame(a, b, ha, ha, hb, 1, 1 + int'($urandom % 3),
                      1 + int'($urandom % 3), -1, "R3");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule